// File: doc/BRIEF.md
# SDRAM Bank Timing Rule Checker

This block sits beside a memory controller and observes the stream of decoded SDRAM commands, at most one per clock. For each of the banks it keeps whether a row is open, how many cycles have passed since the bank was last opened and closed, and whether an auto-precharge is still running. It also keeps a few counters that span all banks: the last column command, the last write, the last refresh and the last mode-register load.

Each command is compared against minimum and maximum spacing limits. Every limit is a module parameter given in clock cycles, taken as the nanosecond figure divided by the clock period and rounded up. When a command breaks one or more rules, the violation pulse and a one-hot-per-rule code appear in the same cycle as that command. A sticky register collects every code bit seen until software-independent logic pulses a synchronous clear. The checker only observes: it never drives the memory, captures data or schedules refresh.

Top module: `sdram_timing_checker`

## Requirements
- R1: After reset all banks are idle, all spacing counters count as expired, `viol`, `viol_code` and `viol_sticky` are zero, and a command presented with `cmd_valid` low has no effect on outputs or tracked state.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE-LOAD=6, BURST-STOP=7; violation bits are 0 open-to-column short, 1 open-to-open same bank short, 2 open-to-open other bank short, 3 row open too short, 4 row open too long, 5 close-to-open short, 6 bank in auto-precharge window, 7 column-to-column short, 8 write-to-read short, 9 refresh recovery short, 10 mode-load recovery short, 11 mode-load with a bank busy, 12 column command to an idle bank, 13 activate to an open bank; `viol` is high in the same cycle as the offending command exactly when some code bit is set.
- R3: A READ or WRITE to an idle bank sets bit 12; to an open bank fewer than T_RCD cycles after its ACTIVATE it sets bit 0.
- R4: An ACTIVATE to an already open bank sets bit 13; an ACTIVATE fewer than T_RC cycles after the previous ACTIVATE to the same bank sets bit 1.
- R5: An ACTIVATE fewer than T_RRD cycles after an ACTIVATE to any other bank sets bit 2.
- R6: A PRECHARGE that closes an open bank sets bit 3 if the bank was open fewer than T_RAS cycles and bit 4 if open more than T_RAS_MAX cycles; a column command with auto-precharge also sets bit 4 on the too-long case.
- R7: An ACTIVATE fewer than T_RP cycles after a PRECHARGE closed that bank sets bit 5.
- R8: A READ with A10 high at cycle n to an open bank closes it and any command to that bank before cycle n + BL/2 + T_RP sets bit 6.
- R9: A WRITE with A10 high at cycle n to an open bank closes it and any command to that bank before cycle n + BL/2 + 1 + T_WR + T_RP sets bit 6.
- R10: A PRECHARGE with A10 high closes every open bank and ignores the bank address; the row-time checks of R6 apply to each bank it closes.
- R11: A column command fewer than T_CCD cycles after the previous one sets bit 7; a READ fewer than T_WTR cycles after a WRITE sets bit 8.
- R12: Any non-NOP command fewer than T_RFC cycles after a REFRESH sets bit 9.
- R13: A MODE-LOAD while any bank is open or in an auto-precharge window sets bit 11; any non-NOP command fewer than T_MRD cycles after a MODE-LOAD sets bit 10.
- R14: `viol_sticky` in the cycle after a command holds its previous value ORed with that command's code; when `sticky_clr` is high it is instead loaded with that cycle's code alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Decoded command code |
| cmd_bank | input | BA_W | Bank address |
| cmd_a10 | input | 1 | Auto-precharge / all-bank select bit |
| sticky_clr | input | 1 | Synchronous clear of the sticky register |
| viol | output | 1 | Rule broken by this cycle's command |
| viol_code | output | 14 | Rules broken by this cycle's command |
| viol_sticky | output | 14 | Accumulated rule bits |

## Verification
A wrong bank state or a counter that is off by one shows at the ports only when a later command reaches that bank or rule, and then in that command's own cycle as a missing or extra code bit; the bench therefore issues commands exactly at each limit and one cycle inside it. A stuck open flag shows as a spurious bit 12 or 13 on the next column command or activate, and a blocking window that ends early or late shows on the command placed at its last or first free cycle. Errors in the sticky path appear one cycle after the command that should have set or cleared them.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        C_NOP  = 3'd0,
        C_ACT  = 3'd1,
        C_RD   = 3'd2,
        C_WR   = 3'd3,
        C_PRE  = 3'd4,
        C_REF  = 3'd5,
        C_MRS  = 3'd6,
        C_BST  = 3'd7
    } cmd_e;

    localparam int VW = 14;
    typedef logic [VW-1:0] vcode_t;

    localparam int VB_RCD      = 0;
    localparam int VB_RC       = 1;
    localparam int VB_RRD      = 2;
    localparam int VB_RAS_LO   = 3;
    localparam int VB_RAS_HI   = 4;
    localparam int VB_RP       = 5;
    localparam int VB_APWIN    = 6;
    localparam int VB_CCD      = 7;
    localparam int VB_WTR      = 8;
    localparam int VB_RFC      = 9;
    localparam int VB_MRD      = 10;
    localparam int VB_MRS_BUSY = 11;
    localparam int VB_IDLE_COL = 12;
    localparam int VB_ACT_OPEN = 13;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_chk_pkg::*;
#(
    parameter int CW        = 15,
    parameter int SATV      = 16001,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 6,
    parameter int T_RAS_MAX = 16000,
    parameter int T_RP      = 3,
    parameter int L_RDAP    = 5,
    parameter int L_WRAP    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  cmd_e          cmd,
    input  logic          ap,
    output vcode_t        code,
    output logic [CW-1:0] act_age,
    output logic          busy
);

    localparam logic [CW-1:0] SAT    = CW'(SATV);
    localparam logic [CW-1:0] K_RCD  = CW'(T_RCD);
    localparam logic [CW-1:0] K_RC   = CW'(T_RC);
    localparam logic [CW-1:0] K_RAS  = CW'(T_RAS);
    localparam logic [CW-1:0] K_RASX = CW'(T_RAS_MAX);
    localparam logic [CW-1:0] K_RP   = CW'(T_RP);
    localparam logic [CW-1:0] K_WRD  = CW'(L_RDAP - 1);
    localparam logic [CW-1:0] K_WWR  = CW'(L_WRAP - 1);

    logic          open_q;
    logic [CW-1:0] age_act_q;
    logic [CW-1:0] age_pre_q;
    logic [CW-1:0] blk_q;

    logic is_col, single, pre_hit, blocked, ap_close;

    always_comb begin
        is_col   = (cmd == C_RD) || (cmd == C_WR);
        single   = sel && ((cmd == C_ACT) || is_col || ((cmd == C_PRE) && !ap));
        pre_hit  = (cmd == C_PRE) && (ap || sel);
        blocked  = (blk_q != '0);
        ap_close = sel && is_col && ap && open_q;
    end

    always_comb begin
        code = '0;
        if ((single || pre_hit) && blocked)
            code[VB_APWIN] = 1'b1;
        if (sel && (cmd == C_ACT)) begin
            if (open_q)            code[VB_ACT_OPEN] = 1'b1;
            if (age_act_q < K_RC)  code[VB_RC]       = 1'b1;
            if (age_pre_q < K_RP)  code[VB_RP]       = 1'b1;
        end
        if (sel && is_col) begin
            if (!open_q)                code[VB_IDLE_COL] = 1'b1;
            else if (age_act_q < K_RCD) code[VB_RCD]      = 1'b1;
        end
        if (ap_close && (age_act_q > K_RASX))
            code[VB_RAS_HI] = 1'b1;
        if (pre_hit && open_q) begin
            if (age_act_q < K_RAS)  code[VB_RAS_LO] = 1'b1;
            if (age_act_q > K_RASX) code[VB_RAS_HI] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            age_act_q <= SAT;
            age_pre_q <= SAT;
            blk_q     <= '0;
        end else begin
            age_act_q <= (age_act_q >= SAT) ? SAT : age_act_q + 1'b1;
            age_pre_q <= (age_pre_q >= SAT) ? SAT : age_pre_q + 1'b1;
            blk_q     <= blocked ? blk_q - 1'b1 : '0;
            if (sel && (cmd == C_ACT)) begin
                open_q    <= 1'b1;
                age_act_q <= CW'(1);
            end else if (ap_close) begin
                open_q <= 1'b0;
                blk_q  <= (cmd == C_WR) ? K_WWR : K_WRD;
            end else if (pre_hit && open_q) begin
                open_q    <= 1'b0;
                age_pre_q <= CW'(1);
            end
        end
    end

    assign act_age = age_act_q;
    assign busy    = open_q || blocked;

endmodule

// File: rtl/sdram_global_track.sv
module sdram_global_track
    import sdram_chk_pkg::*;
#(
    parameter int NB    = 4,
    parameter int BA_W  = 2,
    parameter int CW    = 15,
    parameter int SATV  = 16001,
    parameter int T_RRD = 2,
    parameter int T_CCD = 1,
    parameter int T_WTR = 2,
    parameter int T_RFC = 10,
    parameter int T_MRD = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cmd_e                   cmd,
    input  logic [BA_W-1:0]        bank,
    input  logic [NB-1:0][CW-1:0]  act_ages,
    input  logic                   any_busy,
    output vcode_t                 code
);

    localparam logic [CW-1:0] SAT   = CW'(SATV);
    localparam logic [CW-1:0] K_RRD = CW'(T_RRD);
    localparam logic [CW-1:0] K_CCD = CW'(T_CCD);
    localparam logic [CW-1:0] K_WTR = CW'(T_WTR);
    localparam logic [CW-1:0] K_RFC = CW'(T_RFC);
    localparam logic [CW-1:0] K_MRD = CW'(T_MRD);

    logic [CW-1:0] age_col_q, age_wr_q, age_ref_q, age_mrs_q;
    logic          is_col;

    assign is_col = (cmd == C_RD) || (cmd == C_WR);

    always_comb begin
        code = '0;
        if (cmd != C_NOP) begin
            if (age_ref_q < K_RFC) code[VB_RFC] = 1'b1;
            if (age_mrs_q < K_MRD) code[VB_MRD] = 1'b1;
        end
        if (is_col && (age_col_q < K_CCD))
            code[VB_CCD] = 1'b1;
        if ((cmd == C_RD) && (age_wr_q < K_WTR))
            code[VB_WTR] = 1'b1;
        if ((cmd == C_MRS) && any_busy)
            code[VB_MRS_BUSY] = 1'b1;
        if (cmd == C_ACT) begin
            for (int o = 0; o < NB; o++) begin
                if ((BA_W'(o) != bank) && (act_ages[o] < K_RRD))
                    code[VB_RRD] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age_col_q <= SAT;
            age_wr_q  <= SAT;
            age_ref_q <= SAT;
            age_mrs_q <= SAT;
        end else begin
            age_col_q <= is_col         ? CW'(1) : ((age_col_q >= SAT) ? SAT : age_col_q + 1'b1);
            age_wr_q  <= (cmd == C_WR)  ? CW'(1) : ((age_wr_q  >= SAT) ? SAT : age_wr_q  + 1'b1);
            age_ref_q <= (cmd == C_REF) ? CW'(1) : ((age_ref_q >= SAT) ? SAT : age_ref_q + 1'b1);
            age_mrs_q <= (cmd == C_MRS) ? CW'(1) : ((age_mrs_q >= SAT) ? SAT : age_mrs_q + 1'b1);
        end
    end

endmodule

// File: rtl/sdram_timing_checker.sv
module sdram_timing_checker
    import sdram_chk_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BL        = 4,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 9,
    parameter int T_RRD     = 2,
    parameter int T_RAS     = 6,
    parameter int T_RAS_MAX = 16000,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int T_CCD     = 1,
    parameter int T_WTR     = 2,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [BA_W-1:0] cmd_bank,
    input  logic            cmd_a10,
    input  logic            sticky_clr,
    output logic            viol,
    output logic [VW-1:0]   viol_code,
    output logic [VW-1:0]   viol_sticky
);

    localparam int NB     = 1 << BA_W;
    localparam int L_RDAP = BL / 2 + T_RP;
    localparam int L_WRAP = BL / 2 + 1 + T_WR + T_RP;
    localparam int SATV   = imax(T_RAS_MAX + 1,
                            imax(imax(T_RC, T_RFC), imax(L_WRAP, imax(T_RCD, T_RRD))));
    localparam int CW     = $clog2(SATV + 1);

    cmd_e                  cmd;
    vcode_t                bank_code [NB];
    logic [NB-1:0][CW-1:0] ages;
    logic [NB-1:0]         busy;
    vcode_t                glob_code;
    vcode_t                all_code;
    vcode_t                sticky_q;

    assign cmd = cmd_valid ? cmd_e'(cmd_code) : C_NOP;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_track #(
            .CW(CW), .SATV(SATV), .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS(T_RAS),
            .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP), .L_RDAP(L_RDAP), .L_WRAP(L_WRAP)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .sel     (cmd_bank == BA_W'(b)),
            .cmd     (cmd),
            .ap      (cmd_a10),
            .code    (bank_code[b]),
            .act_age (ages[b]),
            .busy    (busy[b])
        );
    end

    sdram_global_track #(
        .NB(NB), .BA_W(BA_W), .CW(CW), .SATV(SATV), .T_RRD(T_RRD),
        .T_CCD(T_CCD), .T_WTR(T_WTR), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) u_glob (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .bank     (cmd_bank),
        .act_ages (ages),
        .any_busy (|busy),
        .code     (glob_code)
    );

    always_comb begin
        all_code = glob_code;
        for (int b = 0; b < NB; b++)
            all_code = all_code | bank_code[b];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= '0;
        else if (sticky_clr)
            sticky_q <= all_code;
        else
            sticky_q <= sticky_q | all_code;
    end

    assign viol        = |all_code;
    assign viol_code   = all_code;
    assign viol_sticky = sticky_q;

endmodule

// File: rtl/sdram_timing_checker_sva.sv
module sdram_timing_checker_sva
    import sdram_chk_pkg::*;
#(
    parameter int BA_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [2:0]      cmd_code,
    input logic [BA_W-1:0] cmd_bank,
    input logic            sticky_clr,
    input logic            viol,
    input logic [VW-1:0]   viol_code,
    input logic [VW-1:0]   viol_sticky
);

    // R1
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (viol_code == '0 && !viol));

    // R14
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !sticky_clr |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));

    // R14
    sticky_gather_chk: assert property (@(posedge clk) disable iff (rst)
        viol |=> ((viol_sticky & $past(viol_code)) == $past(viol_code)));

    // R4
    act_twice_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == C_ACT && $past(cmd_valid && cmd_code == C_ACT)
         && cmd_bank == $past(cmd_bank)) |-> viol_code[VB_ACT_OPEN]);

    // R3
    rd_after_act_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == C_RD && $past(cmd_valid && cmd_code == C_ACT)
         && cmd_bank == $past(cmd_bank)) |-> viol_code[VB_RCD]);

endmodule

bind sdram_timing_checker sdram_timing_checker_sva #(.BA_W(BA_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .sticky_clr  (sticky_clr),
    .viol        (viol),
    .viol_code   (viol_code),
    .viol_sticky (viol_sticky)
);

// File: tb/test_sdram_timing_checker.sv
module test_sdram_timing_checker;

    localparam int CLK_P     = 10;
    localparam int T_RCD     = 3;
    localparam int T_RC      = 9;
    localparam int T_RRD     = 2;
    localparam int T_RAS     = 6;
    localparam int T_RAS_MAX = 16000;
    localparam int T_RP      = 3;
    localparam int T_WR      = 2;
    localparam int T_CCD     = 1;
    localparam int T_WTR     = 2;
    localparam int T_RFC     = 10;
    localparam int T_MRD     = 2;
    localparam int BL        = 4;
    localparam int FAR       = -100000;

    localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, MRS = 6, BST = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic        cmd_a10 = 1'b0;
    logic        sticky_clr = 1'b0;
    logic        viol;
    logic [13:0] viol_code;
    logic [13:0] viol_sticky;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int t = 0;
    int lact [4];
    int lpre [4];
    int bend [4];
    bit open_m [4];
    int lcol, lwr, lref, lmrs;
    logic [13:0] sticky_m;

    always #(CLK_P/2) clk = ~clk;

    sdram_timing_checker #(
        .BA_W(2), .BL(BL), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RAS(T_RAS),
        .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP), .T_WR(T_WR), .T_CCD(T_CCD),
        .T_WTR(T_WTR), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) i_sdram_timing_checker (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .sticky_clr(sticky_clr),
        .viol(viol), .viol_code(viol_code), .viol_sticky(viol_sticky)
    );

    function automatic logic [13:0] model_code(input int c, input int ba, input bit ap);
        logic [13:0] e = '0;
        bit col = (c == RD) || (c == WR);
        if (c == NOP) return e;
        if (t - lref < T_RFC) e[9] = 1;
        if (t - lmrs < T_MRD) e[10] = 1;
        if (col && (t - lcol < T_CCD)) e[7] = 1;
        if (c == RD && (t - lwr < T_WTR)) e[8] = 1;
        for (int b = 0; b < 4; b++) begin
            bit s = (ba == b);
            bit single = s && (c == ACT || col || (c == PRE && !ap));
            bit ph = (c == PRE) && (ap || s);
            if ((single || ph) && t < bend[b]) e[6] = 1;
            if (c == ACT && !s && (t - lact[b] < T_RRD)) e[2] = 1;
            if (c == MRS && (open_m[b] || t < bend[b])) e[11] = 1;
            if (c == ACT && s) begin
                if (open_m[b]) e[13] = 1;
                if (t - lact[b] < T_RC) e[1] = 1;
                if (t - lpre[b] < T_RP) e[5] = 1;
            end
            if (col && s) begin
                if (!open_m[b]) e[12] = 1;
                else if (t - lact[b] < T_RCD) e[0] = 1;
                if (ap && open_m[b] && (t - lact[b] > T_RAS_MAX)) e[4] = 1;
            end
            if (ph && open_m[b]) begin
                if (t - lact[b] < T_RAS) e[3] = 1;
                if (t - lact[b] > T_RAS_MAX) e[4] = 1;
            end
        end
        return e;
    endfunction

    task automatic model_update(input int c, input int ba, input bit ap);
        if (c == RD || c == WR) lcol = t;
        if (c == WR) lwr = t;
        if (c == REF) lref = t;
        if (c == MRS) lmrs = t;
        for (int b = 0; b < 4; b++) begin
            bit s = (ba == b);
            if (c == ACT && s) begin
                open_m[b] = 1; lact[b] = t;
            end else if ((c == RD || c == WR) && s && ap && open_m[b]) begin
                open_m[b] = 0;
                bend[b] = t + BL/2 + T_RP + ((c == WR) ? (1 + T_WR) : 0);
            end else if (c == PRE && (ap || s) && open_m[b]) begin
                open_m[b] = 0; lpre[b] = t;
            end
        end
    endtask

    task automatic check(input bit ok, input string what, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at t=%0d: actual=%h expected=%h", cur_req, what, t, act, exp);
        end
    endtask

    task automatic step(input bit v, input int c, input int ba, input bit ap, input bit clr);
        logic [13:0] e;
        int ce;
        @(negedge clk);
        cmd_valid = v; cmd_code = 3'(c); cmd_bank = 2'(ba); cmd_a10 = ap; sticky_clr = clr;
        #1;
        ce = v ? c : NOP;
        e = model_code(ce, ba, ap);
        check(viol_code === e, "code", viol_code, e);
        check(viol === (e != 0), "pulse", 14'(viol), 14'(e != 0));
        check(viol_sticky === sticky_m, "sticky", viol_sticky, sticky_m);
        sticky_m = clr ? e : (sticky_m | e);
        model_update(ce, ba, ap);
        t++;
    endtask

    task automatic cmd(input int c, input int ba, input bit ap = 0);
        step(1, c, ba, ap, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, NOP, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) begin
            lact[b] = FAR; lpre[b] = FAR; bend[b] = FAR; open_m[b] = 0;
        end
        lcol = FAR; lwr = FAR; lref = FAR; lmrs = FAR;
        sticky_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        cur_req = "R1";
        check(viol_code === 14'd0, "reset code", viol_code, 14'd0);
        check(viol_sticky === 14'd0, "reset sticky", viol_sticky, 14'd0);
        step(0, ACT, 0, 0, 0);
        cur_req = "R3";                   // R1 too: ACT above must not have opened bank 0
        cmd(RD, 0);
        idle(3);
        // R3 open-to-column spacing
        cmd(ACT, 0); cmd(RD, 0); idle(1); cmd(WR, 0); idle(2);
        // R4 same bank activate
        cur_req = "R4";
        cmd(ACT, 0); idle(5); cmd(PRE, 0); idle(5);
        cmd(ACT, 0); idle(8); cmd(PRE, 0); idle(5);
        // R5 cross-bank activate
        cur_req = "R5";
        cmd(ACT, 1); cmd(ACT, 2); idle(1); cmd(ACT, 3); idle(10);
        cur_req = "R10";
        cmd(PRE, 0, 1); idle(10);
        // R6 short row
        cur_req = "R6";
        cmd(ACT, 0); idle(4); cmd(PRE, 0); idle(10);
        // R7 close-to-open
        cur_req = "R7";
        cmd(ACT, 0); cmd(ACT, 1); idle(1); cmd(ACT, 1); idle(3); cmd(PRE, 1); idle(1);
        cmd(ACT, 1); idle(1); cmd(PRE, 0); idle(10); cmd(ACT, 0); idle(12);
        cur_req = "R10";
        cmd(PRE, 2, 1); idle(10);
        // R8 read auto-precharge window
        cur_req = "R8";
        cmd(ACT, 2); idle(5); cmd(RD, 2, 1); idle(1); cmd(ACT, 2); idle(1); cmd(RD, 2);
        cmd(ACT, 2); idle(9); cmd(PRE, 2); idle(10);
        // R9 write auto-precharge window
        cur_req = "R9";
        cmd(ACT, 3); idle(5); cmd(WR, 3, 1); idle(5); cmd(PRE, 3); cmd(ACT, 3); idle(9);
        cmd(PRE, 3); idle(10);
        // R10 precharge all ignores address
        cur_req = "R10";
        cmd(ACT, 0); idle(1); cmd(ACT, 1); idle(3); cmd(PRE, 3, 1); cmd(RD, 0); cmd(WR, 1);
        idle(10);
        // R11 column spacing
        cur_req = "R11";
        cmd(ACT, 0); idle(3); cmd(RD, 0); cmd(RD, 0); cmd(WR, 0); cmd(RD, 0); idle(1);
        cmd(WR, 0); idle(1); cmd(RD, 0); idle(5); cmd(PRE, 0); idle(5);
        // R12 refresh recovery
        cur_req = "R12";
        cmd(REF, 0); idle(2); cmd(ACT, 1); idle(8); cmd(BST, 0); idle(12); cmd(PRE, 1); idle(5);
        // R13 mode load
        cur_req = "R13";
        cmd(ACT, 2); cmd(MRS, 0); idle(8); cmd(PRE, 2); idle(5);
        cmd(MRS, 0); cmd(ACT, 0); idle(10); cmd(PRE, 0); idle(5);
        cmd(MRS, 0); idle(1); cmd(ACT, 1); idle(8); cmd(PRE, 1); idle(5);
        // R14 sticky clear
        cur_req = "R14";
        step(1, NOP, 0, 0, 1); idle(1);
        cmd(RD, 3); step(1, RD, 3, 0, 1); idle(1); step(1, NOP, 0, 0, 1); idle(2);
        // R2 several rules in one command, pulse matches code
        cur_req = "R2";
        cmd(ACT, 0); cmd(ACT, 0); cmd(RD, 0); idle(8); cmd(PRE, 0); idle(5);
        // R6 long row
        cur_req = "R6";
        cmd(ACT, 1); idle(T_RAS_MAX + 1); cmd(PRE, 1); idle(5);
        cmd(ACT, 2); idle(T_RAS_MAX - 1); cmd(RD, 2, 1); idle(10);
        cmd(ACT, 3); idle(T_RAS_MAX + 1); cmd(WR, 3, 1); idle(10);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule